// File: doc/BRIEF.md
# USB Host Fatal-Error and Interrupt Controller

This block sits next to the DMA engine of a USB 2.0 host controller. It turns read-completion errors, posted transaction status and frame-index wrap events into sticky status bits, a level interrupt line and a halt command for the DMA engine. It also keeps three configuration-space error bits. Software clears each sticky bit by writing a one to it.

A read that the host controller starts and that ends in a master abort or a target abort is a fatal host error. The block records the error at once. It asks the DMA engine to stop, and it lets at most one more USB transaction finish before it reports the controller as halted. A halted controller ignores transaction-done strobes. It ignores posted status until software drops the run/stop bit and raises it again.

Top module: `uhc_fault_irq_ctrl`

## Requirements
- R1: A read response with `rd_rsp_valid` high and code 2'b01 (master abort) or 2'b10 (target abort) is a fatal error, and it sets status bit 2 (host system error) on the next clock edge.
- R2: Code 2'b01 sets configuration bit 0 (received master abort). Code 2'b10 sets configuration bit 1 (received target abort). Codes 2'b00 and 2'b11 are ordinary completions and change no bit.
- R3: A fatal error sets configuration bit 2 (signaled system error) only when `serr_en` is high in the same cycle.
- R4: A fatal error while running with `usb_busy` high moves the block to draining. In that state `dma_halt_req` is 1 and `sts_halted` is 0. The first `xact_done` in that state is acknowledged, and `sts_halted` is 1 after that edge. A fatal error with `usb_busy` low halts on the next edge.
- R5: When a fatal error arrives in the same cycle as `xact_done`, that transaction is acknowledged as the one extra transaction, and the block is halted after that edge.
- R6: While halted, `xact_ack` stays 0 and `dma_halt_req` is 1. After a fatal halt, the block stays halted with `run_stop` high and only runs again once `run_stop` has been seen low and then high. Dropping `run_stop` while running halts the block without a fatal error.
- R7: A `post_valid` with `post_last` high while not halted sets status bit 0 (transfer interrupt) on that edge. A post without `post_last` sets nothing.
- R8: Status bit 1 (frame rollover) is set when the top bit of `frame_idx` falls, which is once every LIST_ENTRIES frames.
- R9: A write with `sts_we` or `cfg_we` clears each bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. A set event in the same cycle wins over the clear.
- R10: `irq` is high exactly while some status bit and its `irq_en` bit (same bit position) are both 1, and it follows `irq_en` in the same cycle.
- R11: `sts_dbe` (data buffer error) always reads 0, including after fatal errors.
- R12: While reset is active: `sts_halted` = 1, `dma_halt_req` = 1, all status and configuration bits are 0, `irq` = 0 and `xact_ack` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_stop | input | 1 | Run/stop command bit |
| irq_en | input | 3 | Interrupt enables, one per status bit |
| serr_en | input | 1 | System-error reporting enable |
| rd_rsp_valid | input | 1 | Read completion strobe |
| rd_rsp_code | input | 2 | Completion code: 00 okay, 01 master abort, 10 target abort, 11 okay |
| usb_busy | input | 1 | A USB transaction is in flight |
| xact_done | input | 1 | USB transaction finished |
| post_valid | input | 1 | Transaction status posted to the internal write buffer |
| post_last | input | 1 | Posted status closes the interrupt interval |
| frame_idx | input | $clog2(LIST_ENTRIES) | Frame list index |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Status write-one-to-clear data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration write-one-to-clear data |
| sts_o | output | 3 | Status: [0] transfer, [1] rollover, [2] host system error |
| sts_dbe | output | 1 | Data buffer error, always 0 |
| sts_halted | output | 1 | Controller halted |
| cfg_o | output | 3 | Config: [0] master abort, [1] target abort, [2] system error |
| irq | output | 1 | Level interrupt request |
| dma_halt_req | output | 1 | Request to the DMA engine to stop |
| xact_ack | output | 1 | Transaction-done strobe accepted |

## Verification
The bench builds the block with LIST_ENTRIES = 8, so the frame index is three bits wide. With that setting several rollover wraps take only a few dozen cycles, so the bench can show over two full laps that the bit sets once per lap and never in between. The other behaviour does not depend on the parameter. Draining, the coincident-abort case, rearming through run/stop and set-beats-clear all run at this setting in a short sequence.

// File: rtl/uhc_fault_pkg.sv
`timescale 1ns/1ps
package uhc_fault_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_MABORT = 2'b01,
    RSP_TABORT = 2'b10,
    RSP_RSVD   = 2'b11
  } rsp_code_e;

  typedef enum logic [1:0] {
    HS_STOPPED = 2'b00,
    HS_RUN     = 2'b01,
    HS_DRAIN   = 2'b10
  } halt_state_e;

  localparam int STS_XFER = 0;
  localparam int STS_ROLL = 1;
  localparam int STS_HSE  = 2;
  localparam int STS_W    = 3;

  localparam int CFG_RMA = 0;
  localparam int CFG_RTA = 1;
  localparam int CFG_SSE = 2;
  localparam int CFG_W   = 3;

  // abort classification of a read completion
  function automatic logic is_fatal(input logic valid, input logic [1:0] code);
    return valid && ((code == RSP_MABORT) || (code == RSP_TABORT));
  endfunction

  // next value of one sticky bit: set wins over clear
  function automatic logic w1c_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // top index bit falling marks a wrap of the frame list
  function automatic logic wrap_seen(input logic prev_msb, input logic cur_msb);
    return prev_msb & ~cur_msb;
  endfunction

endpackage

// File: rtl/uhc_w1c_bank.sv
`timescale 1ns/1ps
module uhc_w1c_bank
  import uhc_fault_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         we_i,
  input  logic [N-1:0] wd_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] clr;
  assign clr = we_i ? wd_i : '0;

  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= w1c_bit(bit_q, set_i[k], clr[k]);
    end

    assign q_o[k] = bit_q;

    assert_w1c_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> q_o[k]);

    assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wd_i[k] && !set_i[k]) |=> !q_o[k]);

    assert_w1c_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[k] && !(we_i && wd_i[k])) |=> q_o[k]);
  end

endmodule

// File: rtl/uhc_frame_wrap.sv
`timescale 1ns/1ps
module uhc_frame_wrap
  import uhc_fault_pkg::*;
#(
  parameter  int LIST_ENTRIES = 1024,
  localparam int IDX_W        = $clog2(LIST_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] frame_idx_i,
  output logic             wrap_o
);

  logic msb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msb_q <= 1'b0;
    else        msb_q <= frame_idx_i[IDX_W-1];
  end

  assign wrap_o = wrap_seen(msb_q, frame_idx_i[IDX_W-1]);

  assert_wrap_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> ($past(frame_idx_i[IDX_W-1]) && !frame_idx_i[IDX_W-1]));

endmodule

// File: rtl/uhc_halt_seq.sv
`timescale 1ns/1ps
module uhc_halt_seq
  import uhc_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_stop_i,
  input  logic fatal_i,
  input  logic usb_busy_i,
  input  logic xact_done_i,
  output logic halted_o,
  output logic halt_req_o,
  output logic xact_ack_o
);

  halt_state_e state_q, state_d;
  logic        rearm_q, rearm_d;
  logic        drain_exit;

  // the extra transaction ends, or none is in flight
  assign drain_exit = xact_done_i || !usb_busy_i;

  always_comb begin
    state_d = state_q;
    rearm_d = rearm_q;
    unique case (state_q)
      HS_STOPPED: begin
        if (fatal_i)               rearm_d = 1'b1;
        else if (!run_stop_i)      rearm_d = 1'b0;
        else if (!rearm_q)         state_d = HS_RUN;
      end
      HS_RUN: begin
        if (fatal_i) begin
          if (drain_exit) begin
            state_d = HS_STOPPED;
            rearm_d = 1'b1;
          end else begin
            state_d = HS_DRAIN;
          end
        end else if (!run_stop_i) begin
          state_d = HS_STOPPED;
        end
      end
      HS_DRAIN: begin
        if (drain_exit) begin
          state_d = HS_STOPPED;
          rearm_d = 1'b1;
        end
      end
      default: state_d = HS_STOPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_STOPPED;
      rearm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rearm_q <= rearm_d;
    end
  end

  assign halted_o   = (state_q == HS_STOPPED);
  assign halt_req_o = (state_q != HS_RUN);
  assign xact_ack_o = xact_done_i && (state_q != HS_STOPPED);

  assert_drain_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_DRAIN && drain_exit) |=> halted_o);

  assert_drain_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && fatal_i && usb_busy_i && !xact_done_i) |=> (halt_req_o && !halted_o));

  assert_coincident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RUN && fatal_i && xact_done_i) |=> halted_o);

  assert_rearm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && rearm_q) |=> halted_o);

endmodule

// File: rtl/uhc_fault_irq_ctrl.sv
`timescale 1ns/1ps
module uhc_fault_irq_ctrl
  import uhc_fault_pkg::*;
#(
  parameter  int LIST_ENTRIES = 1024,
  localparam int IDX_W        = $clog2(LIST_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_stop,
  input  logic [2:0]       irq_en,
  input  logic             serr_en,
  input  logic             rd_rsp_valid,
  input  logic [1:0]       rd_rsp_code,
  input  logic             usb_busy,
  input  logic             xact_done,
  input  logic             post_valid,
  input  logic             post_last,
  input  logic [IDX_W-1:0] frame_idx,
  input  logic             sts_we,
  input  logic [2:0]       sts_wdata,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  output logic [2:0]       sts_o,
  output logic             sts_dbe,
  output logic             sts_halted,
  output logic [2:0]       cfg_o,
  output logic             irq,
  output logic             dma_halt_req,
  output logic             xact_ack
);

  // named internal events
  logic             fatal_ev;
  logic             mabort_ev;
  logic             tabort_ev;
  logic             post_ev;
  logic             wrap_ev;
  logic [STS_W-1:0] sts_set;
  logic [CFG_W-1:0] cfg_set;

  assign fatal_ev  = is_fatal(rd_rsp_valid, rd_rsp_code);
  assign mabort_ev = rd_rsp_valid && (rd_rsp_code == RSP_MABORT);
  assign tabort_ev = rd_rsp_valid && (rd_rsp_code == RSP_TABORT);
  assign post_ev   = post_valid && post_last && !sts_halted;

  uhc_halt_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_stop_i  (run_stop),
    .fatal_i     (fatal_ev),
    .usb_busy_i  (usb_busy),
    .xact_done_i (xact_done),
    .halted_o    (sts_halted),
    .halt_req_o  (dma_halt_req),
    .xact_ack_o  (xact_ack)
  );

  uhc_frame_wrap #(.LIST_ENTRIES(LIST_ENTRIES)) u_wrap (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_idx_i (frame_idx),
    .wrap_o      (wrap_ev)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[STS_XFER] = post_ev;
    sts_set[STS_ROLL] = wrap_ev;
    sts_set[STS_HSE]  = fatal_ev;
    cfg_set           = '0;
    cfg_set[CFG_RMA]  = mabort_ev;
    cfg_set[CFG_RTA]  = tabort_ev;
    cfg_set[CFG_SSE]  = fatal_ev && serr_en;
  end

  uhc_w1c_bank #(.N(STS_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sts_set),
    .we_i  (sts_we),
    .wd_i  (sts_wdata),
    .q_o   (sts_o)
  );

  uhc_w1c_bank #(.N(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (cfg_set),
    .we_i  (cfg_we),
    .wd_i  (cfg_wdata),
    .q_o   (cfg_o)
  );

  assign irq     = |(sts_o & irq_en);
  assign sts_dbe = 1'b0;

  assert_fatal_hse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_fatal(rd_rsp_valid, rd_rsp_code) |=> sts_o[STS_HSE]);

  assert_mabort_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && rd_rsp_code == 2'b01) |=> cfg_o[CFG_RMA]);

  assert_tabort_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && rd_rsp_code == 2'b10) |=> cfg_o[CFG_RTA]);

  assert_sse_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_o[CFG_SSE]) |-> $past(serr_en));

  assert_post_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_last && !sts_halted) |=> sts_o[STS_XFER]);

  assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> sts_o[STS_ROLL]);

  assert_halted_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_halted && $past(sts_halted) && xact_done) |-> !xact_ack);

endmodule

// File: tb/sim_uhc_fault_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uhc_fault_irq_ctrl;

  localparam int LE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rs = 0, rv = 0, busy = 0, done = 0, post = 0, last = 0;
  logic       swe = 0, serr = 0, cwe = 0;
  logic [1:0] rc = '0;
  logic [2:0] swd = '0, ie = '0, cwd = '0, fidx = '0;
  logic [2:0] sts, cfg;
  logic       dbe, halted, irq, hreq, ack;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uhc_fault_irq_ctrl #(.LIST_ENTRIES(LE)) u0 (
    .clk(clk), .rst_n(rst_n), .run_stop(rs), .irq_en(ie), .serr_en(serr),
    .rd_rsp_valid(rv), .rd_rsp_code(rc), .usb_busy(busy), .xact_done(done),
    .post_valid(post), .post_last(last), .frame_idx(fidx),
    .sts_we(swe), .sts_wdata(swd), .cfg_we(cwe), .cfg_wdata(cwd),
    .sts_o(sts), .sts_dbe(dbe), .sts_halted(halted), .cfg_o(cfg),
    .irq(irq), .dma_halt_req(hreq), .xact_ack(ack)
  );

  // inputs [29:10]: rs rv rc[2] busy done post last swe swd[3] ie[3] serr cwe cwd[3]
  // expect  [9:0]:  ack halted hreq sts[3] cfg[3] irq
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    30'b1_0_00_0_0_0_0_0_000_000_0_0_000_0_0_0_000_000_0,  // R6 start
    30'b1_0_00_0_1_1_1_0_000_001_0_0_000_1_0_0_001_000_1,  // R7 R10
    30'b1_0_00_0_0_0_0_1_001_001_0_0_000_0_0_0_000_000_0,  // R9
    30'b1_0_00_0_1_1_0_0_000_001_0_0_000_1_0_0_000_000_0,  // R7 no last
    30'b1_1_01_1_0_0_0_0_000_100_0_0_000_0_0_1_100_001_1,  // R1 R2 R4
    30'b1_0_00_1_1_0_0_0_000_100_0_0_000_1_1_1_100_001_1,  // R4 extra done
    30'b1_0_00_1_1_1_1_0_000_000_0_0_000_0_1_1_100_001_0,  // R6 ignored
    30'b0_0_00_0_0_0_0_1_100_000_0_0_000_0_1_1_000_001_0,  // R6 R9
    30'b1_0_00_0_0_0_0_0_000_000_0_0_000_0_0_0_000_001_0,  // R6 rerun
    30'b1_1_10_1_1_0_0_0_000_100_1_0_000_1_1_1_100_111_1,  // R2 R3 R5
    30'b1_1_00_0_0_0_0_0_000_100_0_0_000_0_1_1_100_111_1,  // R2 okay
    30'b1_0_00_0_1_0_0_0_000_100_0_0_000_0_1_1_100_111_1,  // R6 hold
    30'b0_0_00_0_0_0_0_1_100_100_0_1_011_0_1_1_000_100_0,  // R9 cfg
    30'b0_0_00_0_0_0_0_0_000_000_0_1_100_0_1_1_000_000_0,  // R9 cfg
    30'b1_0_00_0_0_0_0_0_000_000_0_0_000_0_0_0_000_000_0,  // R6 rearmed
    30'b1_1_11_1_0_0_0_0_000_100_1_0_000_0_0_0_000_000_0,  // R2 code 11
    30'b1_1_01_0_0_0_0_0_000_000_1_0_000_0_1_1_100_101_0   // R3 R4 idle
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R6";       1: return "R7 R10";   2: return "R9";
      3: return "R7";       4: return "R1 R2 R4"; 5: return "R4";
      6: return "R6";       7: return "R6 R9";    8: return "R6";
      9: return "R3 R5";    10: return "R2";      11: return "R6";
      12: return "R9";      13: return "R9";      14: return "R6";
      15: return "R2";      default: return "R3 R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {rv, rc, busy, done, post, last, swe, swd, cwe, cwd} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R12 reset state
    ie = 3'b111; done = 1'b1; rs = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset outputs", {10'd0, halted, hreq, sts, irq},   {10'd0, 1'b1, 1'b1, 3'b000, 1'b0});
    check("R12 reset cfg ack", {12'd0, cfg, ack}, 16'd0);
    @(negedge clk);
    rs = 0; done = 0; ie = '0;
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rs, rv, rc, busy, done, post, last, swe, swd, ie, serr, cwe, cwd} = VEC[i][29:10];
      #1;
      check({row_tag(i), " ack"}, {15'd0, ack}, {15'd0, VEC[i][9]});
      @(posedge clk);
      #1;
      check({row_tag(i), " regs"}, {7'd0, halted, hreq, sts, cfg, irq}, {7'd0, VEC[i][8:0]});
      check("R11 dbe", {15'd0, dbe}, 16'd0);
    end

    // R12 mid-run reset with strobes asserted
    @(negedge clk);
    idle_inputs(); rs = 1; done = 1; ie = 3'b111;
    rst_n = 1'b0;
    #1;
    check("R12 async reset", {8'd0, halted, hreq, sts, cfg, ack, irq} , {8'd0, 1'b1, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0});
    @(negedge clk);
    done = 0; ie = '0; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R6 run after reset", {15'd0, halted}, 16'd0);

    // R9 set beats clear
    @(negedge clk);
    done = 1; post = 1; last = 1; swe = 1; swd = 3'b001;
    @(posedge clk); #1;
    check("R9 set wins", {13'd0, sts}, 16'b001);
    @(negedge clk);
    idle_inputs(); swe = 1; swd = 3'b110;
    @(posedge clk); #1;
    check("R9 write zero keeps", {13'd0, sts}, 16'b001);

    // R10 level output follows enables
    @(negedge clk);
    idle_inputs(); ie = 3'b000; #1;
    check("R10 masked", {15'd0, irq}, 16'd0);
    ie = 3'b001; #1;
    check("R10 enabled", {15'd0, irq}, 16'd1);
    ie = 3'b010; #1;
    check("R10 other enable", {15'd0, irq}, 16'd0);

    // R8 rollover over two laps
    for (int lap = 0; lap < 2; lap++) begin
      for (int k = 1; k <= LE; k++) begin
        @(negedge clk);
        idle_inputs();
        fidx = 3'(k % LE);
        if (k == 1) begin swe = 1; swd = 3'b010; end
        @(posedge clk); #1;
        check("R8 rollover", {15'd0, sts[1]}, {15'd0, (k == LE)});
        if (k == LE) check("R8 R10 rollover irq", {15'd0, irq}, 16'd1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule